// File: doc/BRIEF.md
# State Machine Interrupt Flag Unit

This block keeps a small bank of shared event flags for a group of programmable I/O state machines. Each machine can raise a flag, lower it, raise it and then hold until some other agent lowers it again, or hold until a flag goes high. When a wait of that last kind completes, the flag is consumed. A machine may name a flag by its absolute number or by a number relative to its own ID. In the relative case the machine ID is added to the low two bits of the index, modulo 4. The upper index bit passes through unchanged.

The lower half of the flag bank also faces a processor. The processor can read those flags, lower them with a write-one-to-clear mask, and route each of them to a level interrupt line through a per-flag enable register. The upper half of the bank is private to the state machines. All requests that arrive in the same cycle are resolved with fixed priorities. Any raise beats any lowering of the same flag. When several machines wait on the same high flag, the lowest-numbered machine wins it.

Top module: `sm_flag_unit`

## Requirements
- R1: After reset all flags are low, no machine is stalled, the interrupt enables are zero and every interrupt output is low.
- R2: A request with op code 0 (raise) sets the resolved flag, and op code 1 (lower) clears it. The change is visible on `flag_level` in the cycle after the request.
- R3: With `sm_rel` high, machine N resolves index I to {I[2], (I[1:0]+N) mod 4}. With `sm_rel` low, I is used unchanged.
- R4: If a raise and any clear (from a machine, from a wait completion or from the processor) hit the same flag in one cycle, the flag ends up high.
- R5: Op code 2 (raise-and-hold) sets the flag and stalls its machine in the issue cycle. The machine stays stalled in every later cycle in which that flag is high. The stall drops in the first cycle that finds the flag low. While the machine holds, its repeated request is ignored, so the flag is not raised again.
- R6: Op code 3 (wait-high) stalls its machine while the resolved flag is low. In a cycle where the flag is high, the wait completes without a stall and the flag is low in the next cycle.
- R7: When two or more machines wait-high on the same high flag in one cycle, only the lowest-numbered machine completes. The others stay stalled.
- R8: `host_flags` shows flags 0 to 3. A cycle with `host_clr_valid` high clears each of those flags whose bit is 1 in `host_clr_mask`.
- R9: Flags 4 to 7 are never changed by a processor clear.
- R10: `host_en_we` loads `host_en_wdata` into the enable register, which reads back on `host_en`. `irq_o[j]` is high exactly when flag j and enable bit j are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sm_valid | input | NUM_SM | Per-machine request valid |
| sm_op | input | 2*NUM_SM | Per-machine op code: 0 raise, 1 lower, 2 raise-and-hold, 3 wait-high |
| sm_rel | input | NUM_SM | Per-machine relative-index select |
| sm_idx | input | IDXW*NUM_SM | Per-machine flag index |
| host_clr_valid | input | 1 | Processor clear strobe |
| host_clr_mask | input | NUM_HOST | Write-one-to-clear mask for processor-visible flags |
| host_en_we | input | 1 | Interrupt enable write strobe |
| host_en_wdata | input | NUM_HOST | Interrupt enable write data |
| sm_stall | output | NUM_SM | Per-machine stall |
| flag_level | output | NUM_FLAGS | Current level of every flag |
| host_flags | output | NUM_HOST | Processor view of flags 0 to 3 |
| host_en | output | NUM_HOST | Interrupt enable readback |
| irq_o | output | NUM_HOST | Level interrupt outputs |

## Verification
The bench builds the block with its defaults: four machines, eight flags and four processor-visible flags. With four machines, machine 3 can be made to wrap its relative index past the modulo boundary, and a relative index can be run with bit 2 set. Two or more waiters can contend for the same flag. A processor clear can be aimed at all four visible flags while the internal flags are held high.

// File: rtl/flag_pkg.sv
package flag_pkg;

    typedef enum logic [1:0] {
        OP_RAISE    = 2'd0,
        OP_LOWER    = 2'd1,
        OP_RAISE_HOLD = 2'd2,
        OP_WAIT_HIGH  = 2'd3
    } flag_op_e;

endpackage

// File: rtl/flag_index_map.sv
module flag_index_map #(
    parameter int NUM_SM    = 4,
    parameter int NUM_FLAGS = 8,
    parameter int SM_ID     = 0
) (
    input  logic                         rel,
    input  logic [$clog2(NUM_FLAGS)-1:0] idx_in,
    output logic [$clog2(NUM_FLAGS)-1:0] idx_out
);
    localparam int IDXW = $clog2(NUM_FLAGS);
    localparam int RW   = $clog2(NUM_SM);
    localparam logic [RW-1:0] ID_BITS = RW'(SM_ID);

    logic [RW-1:0] low_sum;

    always_comb begin
        low_sum = idx_in[RW-1:0] + ID_BITS;
        idx_out = idx_in;
        if (rel) begin
            idx_out[RW-1:0] = low_sum;
        end
    end

    // relative resolution never changes the upper index bits (R3)
    always_comb begin
        assert_upper_kept_R3: assert (idx_out[IDXW-1:RW] == idx_in[IDXW-1:RW]);
    end
endmodule

// File: rtl/flag_host_regs.sv
module flag_host_regs #(
    parameter int NUM_HOST = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_we,
    input  logic [NUM_HOST-1:0] en_wdata,
    input  logic [NUM_HOST-1:0] flags,
    output logic [NUM_HOST-1:0] en_o,
    output logic [NUM_HOST-1:0] irq_o
);
    typedef struct packed {
        logic [NUM_HOST-1:0] en;
    } host_state_t;

    host_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en_we) begin
            s_d.en = en_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_o  = s_q.en;
    assign irq_o = flags & s_q.en;

    assert_en_zero_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && en_wdata == '0) |=> (irq_o == '0));
endmodule

// File: rtl/sm_flag_unit.sv
module sm_flag_unit
    import flag_pkg::*;
#(
    parameter int NUM_SM    = 4,
    parameter int NUM_FLAGS = 8,
    parameter int NUM_HOST  = 4,
    localparam int IDXW     = $clog2(NUM_FLAGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SM-1:0]        sm_valid,
    input  logic [2*NUM_SM-1:0]      sm_op,
    input  logic [NUM_SM-1:0]        sm_rel,
    input  logic [IDXW*NUM_SM-1:0]   sm_idx,
    input  logic                     host_clr_valid,
    input  logic [NUM_HOST-1:0]      host_clr_mask,
    input  logic                     host_en_we,
    input  logic [NUM_HOST-1:0]      host_en_wdata,
    output logic [NUM_SM-1:0]        sm_stall,
    output logic [NUM_FLAGS-1:0]     flag_level,
    output logic [NUM_HOST-1:0]      host_flags,
    output logic [NUM_HOST-1:0]      host_en,
    output logic [NUM_HOST-1:0]      irq_o
);
    typedef struct packed {
        logic [NUM_FLAGS-1:0]           flags;
        logic [NUM_SM-1:0]              holding;
        logic [NUM_SM-1:0][IDXW-1:0]    hold_idx;
    } unit_state_t;

    unit_state_t s_d, s_q;

    logic [NUM_SM-1:0][IDXW-1:0] ridx;
    logic [NUM_FLAGS-1:0]        set_m;
    logic [NUM_FLAGS-1:0]        clr_m;
    logic [NUM_FLAGS-1:0]        claimed;
    logic [NUM_FLAGS-1:0]        host_clr_full;

    for (genvar g = 0; g < NUM_SM; g++) begin : g_map
        flag_index_map #(
            .NUM_SM   (NUM_SM),
            .NUM_FLAGS(NUM_FLAGS),
            .SM_ID    (g)
        ) u_map (
            .rel    (sm_rel[g]),
            .idx_in (sm_idx[g*IDXW +: IDXW]),
            .idx_out(ridx[g])
        );
    end

    always_comb begin
        s_d           = s_q;
        set_m         = '0;
        clr_m         = '0;
        claimed       = '0;
        sm_stall      = '0;
        host_clr_full = '0;
        // machines scanned in ascending order: lower ID wins a contended wait
        for (int i = 0; i < NUM_SM; i++) begin
            if (s_q.holding[i]) begin
                if (s_q.flags[s_q.hold_idx[i]]) begin
                    sm_stall[i] = 1'b1;
                end else begin
                    s_d.holding[i] = 1'b0;
                end
            end else if (sm_valid[i]) begin
                case (flag_op_e'(sm_op[i*2 +: 2]))
                    OP_RAISE: set_m[ridx[i]] = 1'b1;
                    OP_LOWER: clr_m[ridx[i]] = 1'b1;
                    OP_RAISE_HOLD: begin
                        set_m[ridx[i]]    = 1'b1;
                        s_d.holding[i]    = 1'b1;
                        s_d.hold_idx[i]   = ridx[i];
                        sm_stall[i]       = 1'b1;
                    end
                    default: begin
                        if (s_q.flags[ridx[i]] && !claimed[ridx[i]]) begin
                            claimed[ridx[i]] = 1'b1;
                            clr_m[ridx[i]]   = 1'b1;
                        end else begin
                            sm_stall[i] = 1'b1;
                        end
                    end
                endcase
            end
        end
        if (host_clr_valid) begin
            host_clr_full[NUM_HOST-1:0] = host_clr_mask;
        end
        s_d.flags = (s_q.flags & ~clr_m & ~host_clr_full) | set_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_level = s_q.flags;
    assign host_flags = s_q.flags[NUM_HOST-1:0];

    flag_host_regs #(.NUM_HOST(NUM_HOST)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (host_en_we),
        .en_wdata(host_en_wdata),
        .flags   (s_q.flags[NUM_HOST-1:0]),
        .en_o    (host_en),
        .irq_o   (irq_o)
    );

    for (genvar a = 0; a < NUM_SM; a++) begin : g_chk
        assert_raise_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (sm_valid[a] && !s_q.holding[a] && sm_op[a*2 +: 2] == 2'd0)
            |=> flag_level[$past(ridx[a])]);
        assert_hold_persists_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (sm_valid[a] && !s_q.holding[a] && sm_op[a*2 +: 2] == 2'd2)
            |=> sm_stall[a]);
    end

    assert_host_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clr_valid && sm_valid == '0)
        |=> ((host_flags & $past(host_clr_mask)) == '0));
    assert_internal_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clr_valid && sm_valid == '0 && s_q.holding == '0)
        |=> $stable(flag_level[NUM_FLAGS-1:NUM_HOST]));
endmodule

// File: tb/sim_sm_flag_unit.sv
`timescale 1ns/1ps
module sim_sm_flag_unit;
    localparam int NSM = 4;
    localparam int NF  = 8;
    localparam int NH  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NSM-1:0]   valid;
    logic [2*NSM-1:0] op;
    logic [NSM-1:0]   rel;
    logic [3*NSM-1:0] idx;
    logic          hclr_v;
    logic [NH-1:0] hclr_m;
    logic          en_we;
    logic [NH-1:0] en_wd;
    logic [NSM-1:0] stall;
    logic [NF-1:0]  flags;
    logic [NH-1:0]  hflags;
    logic [NH-1:0]  hen;
    logic [NH-1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sm_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .sm_valid(valid), .sm_op(op), .sm_rel(rel),
        .sm_idx(idx), .host_clr_valid(hclr_v), .host_clr_mask(hclr_m),
        .host_en_we(en_we), .host_en_wdata(en_wd), .sm_stall(stall),
        .flag_level(flags), .host_flags(hflags), .host_en(hen), .irq_o(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        valid = '0; op = '0; rel = '0; idx = '0;
        hclr_v = 1'b0; hclr_m = '0; en_we = 1'b0; en_wd = '0;
    endtask

    task automatic req(int m, logic [1:0] o, logic r, logic [2:0] i);
        valid[m] = 1'b1;
        op[m*2 +: 2] = o;
        rel[m] = r;
        idx[m*3 +: 3] = i;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic wipe();
        idle_all();
        for (int m = 0; m < NSM; m++) req(m, 2'd1, 1'b0, 3'(4 + m));
        hclr_v = 1'b1; hclr_m = '1;
        tick();
        idle_all();
    endtask

    task automatic t_reset();
        chk("R1 flags", 32'(flags), 0);
        chk("R1 stall", 32'(stall), 0);
        chk("R1 enable", 32'(hen), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_raise_lower();
        req(0, 2'd0, 1'b0, 3'd5);
        tick(); idle_all();
        chk("R2 raise flag 5", 32'(flags), 32'h20);
        req(2, 2'd1, 1'b0, 3'd5);
        tick(); idle_all();
        chk("R2 lower flag 5", 32'(flags), 0);
    endtask

    task automatic t_relative();
        // machine 3, index 6 -> {1, (2+3)%4} = 5
        req(3, 2'd0, 1'b1, 3'd6);
        tick(); idle_all();
        chk("R3 m3 rel 6", 32'(flags), 32'h20);
        // machine 1, index 3 -> {0, (3+1)%4} = 0
        req(1, 2'd0, 1'b1, 3'd3);
        tick(); idle_all();
        chk("R3 m1 rel 3", 32'(flags), 32'h21);
        wipe();
        // absolute path ignores machine ID
        req(2, 2'd0, 1'b0, 3'd1);
        tick(); idle_all();
        chk("R3 m2 absolute 1", 32'(flags), 32'h02);
        wipe();
    endtask

    task automatic t_set_wins();
        req(0, 2'd0, 1'b0, 3'd2);
        req(1, 2'd1, 1'b0, 3'd2);
        hclr_v = 1'b1; hclr_m = 4'b0100;
        tick(); idle_all();
        chk("R4 raise beats clears", 32'(flags), 32'h04);
        wipe();
    endtask

    task automatic t_hold();
        req(1, 2'd2, 1'b0, 3'd4);
        #1;
        chk("R5 stall at issue", 32'(stall[1]), 1);
        tick();
        chk("R5 flag raised", 32'(flags[4]), 1);
        chk("R5 stall while high", 32'(stall[1]), 1);
        tick();
        chk("R5 still stalled", 32'(stall[1]), 1);
        req(0, 2'd1, 1'b0, 3'd4);
        #1;
        chk("R5 stalled in clear cycle", 32'(stall[1]), 1);
        tick();
        valid[0] = 1'b0;
        #1;
        chk("R5 stall drops", 32'(stall[1]), 0);
        tick(); idle_all();
        chk("R5 no re-raise", 32'(flags[4]), 0);
        wipe();
    endtask

    task automatic t_wait();
        req(2, 2'd3, 1'b0, 3'd6);
        req(0, 2'd0, 1'b0, 3'd6);
        #1;
        chk("R6 stall while low", 32'(stall[2]), 1);
        tick();
        valid[0] = 1'b0;
        #1;
        chk("R6 completes when high", 32'(stall[2]), 0);
        tick(); idle_all();
        chk("R6 flag consumed", 32'(flags[6]), 0);
        wipe();
    endtask

    task automatic t_priority();
        req(0, 2'd0, 1'b0, 3'd1);
        tick(); idle_all();
        req(3, 2'd3, 1'b0, 3'd1);
        req(1, 2'd3, 1'b0, 3'd1);
        #1;
        chk("R7 lower ID wins", 32'(stall[1]), 0);
        chk("R7 higher ID stalls", 32'(stall[3]), 1);
        tick();
        valid[1] = 1'b0;
        #1;
        chk("R7 flag consumed once", 32'(flags[1]), 0);
        chk("R7 loser still stalled", 32'(stall[3]), 1);
        idle_all();
        wipe();
    endtask

    task automatic t_host();
        req(0, 2'd0, 1'b0, 3'd0);
        req(1, 2'd0, 1'b0, 3'd3);
        req(2, 2'd0, 1'b0, 3'd7);
        tick(); idle_all();
        chk("R8 host view", 32'(hflags), 32'h9);
        hclr_v = 1'b1; hclr_m = 4'b1111;
        tick(); idle_all();
        chk("R8 host clear", 32'(hflags), 0);
        chk("R9 internal flag kept", 32'(flags), 32'h80);
        wipe();
    endtask

    task automatic t_irq();
        req(0, 2'd0, 1'b0, 3'd2);
        req(1, 2'd0, 1'b0, 3'd3);
        en_we = 1'b1; en_wd = 4'b0100;
        tick(); idle_all();
        chk("R10 enable readback", 32'(hen), 32'h4);
        chk("R10 gated irq", 32'(irq), 32'h4);
        en_we = 1'b1; en_wd = 4'b0000;
        tick(); idle_all();
        chk("R10 irq off", 32'(irq), 0);
        wipe();
    endtask

    initial begin
        #(5.0 * 50000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_raise_lower();
        t_relative();
        t_set_wins();
        t_hold();
        t_wait();
        t_priority();
        t_host();
        t_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule